// File: doc/BRIEF.md
# Drive Bay Control Register File

This block holds the control registers for a backplane carrying two storage drives. It sits on a synchronous host bus with a 16-bit address, 8-bit data, a write strobe and a read strobe. The block answers in the window 0xF800 to 0xFFFF. That window is cut into eight regions of 256 bytes each, and address bits [10:8] select the region. Each region holds one byte-wide register. The low address byte is not decoded, so every address in a region reaches the same register.

Two regions are implemented. One holds the fault indicator enables, one bit for each drive. The other holds the drive power enables, also one bit for each drive. The block has two reset inputs. A warm reset clears the fault indicators and leaves drive power alone. A cold reset clears the fault indicators and turns power on for every drive whose presence input is high. All other regions, including the unused top region, read as zero and ignore writes.

Top module: `drive_bay_regs`

## Requirements
- R1: The block decodes only addresses whose bits [15:11] are all ones. Inside that window, address bits [10:8] select the region: region 0 (0xF8xx) is the fault register and region 1 (0xF9xx) is the power register.
- R2: Address bits [7:0] are ignored. Every byte address in a region reads and writes the same register.
- R3: When `wrEn` is high and neither reset is high, the addressed register takes `wrData[1:0]` at the next rising clock edge. Bit i controls drive i: `faultLed[i]` and `drivePower[i]` are 1 for on and 0 for off.
- R4: Reads are combinational. With `rdEn` high, `rdData` is `{6'b0, register}` for the selected register. `rdData` is 0x00 whenever `rdEn` is low. Writes to bits [7:2] are discarded, and those bits always read as zero.
- R5: A warm reset leaves `drivePower` unchanged.
- R6: At any clock edge where warm or cold reset is high, both fault bits clear to zero. While either reset is high, host writes are ignored.
- R7: At each clock edge where `coldRst` is high, `drivePower` loads `drivePresent`. This happens even if `warmRst` is also high: cold reset wins.
- R8: Regions 2 through 7, and all addresses outside the window, read as 0x00. Writes to them change neither register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus and register clock |
| coldRst | input | 1 | Synchronous cold reset, active high |
| warmRst | input | 1 | Synchronous warm reset, active high |
| addr | input | 16 | Host byte address |
| wrEn | input | 1 | Write strobe |
| wrData | input | 8 | Write data |
| rdEn | input | 1 | Read strobe |
| rdData | output | 8 | Combinational read data |
| drivePresent | input | 2 | Presence input for each drive |
| faultLed | output | 2 | Fault indicator enables, bit i for drive i |
| drivePower | output | 2 | Power enables, bit i for drive i |

## Verification
The embedded assertions check the following on every cycle:
- the reserved read bits are always zero;
- a warm reset leaves power untouched and clears the fault bits;
- the power bits hold the presence value after a cold reset;
- a decoded write lands in its register;
- reads that miss return zero.

Some behaviours only the directed scenarios can show:
- aliasing across the whole low address byte;
- writes to unused regions and to addresses outside the window leaving both registers intact;
- cold reset winning over a simultaneous warm reset;
- writes being dropped while a reset is held.

// File: rtl/drive_bay_pkg.sv
package drive_bay_pkg;

  // Strobes passed from the decoder to the register datapath
  typedef struct packed {
    logic faultWr;    // write fault register
    logic powerWr;    // write power register
    logic faultRd;    // fault register selected for read
    logic powerRd;    // power register selected for read
    logic clearFault; // any reset clears indicators
    logic loadPower;  // cold reset loads presence
  } bayStrobesT;

endpackage

// File: rtl/drive_bay_ctrl.sv
module drive_bay_ctrl
  import drive_bay_pkg::*;
#(
  parameter int ADDR_W       = 16,
  parameter int OFFSET_W     = 8,
  parameter int REGION_W     = 3,
  parameter logic [ADDR_W-1:0] WINDOW_BASE = 16'hF800,
  parameter int FAULT_REGION = 0,
  parameter int POWER_REGION = 1
) (
  input  logic              coldRst,
  input  logic              warmRst,
  input  logic [ADDR_W-1:0] addr,
  input  logic              wrEn,
  input  logic              rdEn,
  output bayStrobesT        strobes
);

  localparam int TAG_LSB = OFFSET_W + REGION_W;

  logic                inWindow;
  logic [REGION_W-1:0] regionIdx;
  logic                anyRst;
  logic                hitFault;
  logic                hitPower;
  logic                unusedOffset;

  // The low offset bits are not decoded, so every byte of a region aliases.
  assign unusedOffset = ^addr[OFFSET_W-1:0];

  assign inWindow  = (addr[ADDR_W-1:TAG_LSB] == WINDOW_BASE[ADDR_W-1:TAG_LSB]);
  assign regionIdx = addr[TAG_LSB-1:OFFSET_W];
  assign anyRst    = coldRst | warmRst;

  assign hitFault = inWindow && (regionIdx == REGION_W'(FAULT_REGION));
  assign hitPower = inWindow && (regionIdx == REGION_W'(POWER_REGION));

  always_comb begin
    strobes            = '0;
    strobes.faultWr    = wrEn && hitFault && !anyRst;
    strobes.powerWr    = wrEn && hitPower && !anyRst;
    strobes.faultRd    = rdEn && hitFault;
    strobes.powerRd    = rdEn && hitPower;
    strobes.clearFault = anyRst;
    strobes.loadPower  = coldRst;
  end

  // R6: no register write strobe may fire while a reset is held
  always_comb begin
    if (anyRst) begin
      a_r6_no_write_in_reset: assert (!strobes.faultWr && !strobes.powerWr);
    end
  end

endmodule

// File: rtl/drive_bay_dp.sv
module drive_bay_dp
  import drive_bay_pkg::*;
#(
  parameter int DATA_W     = 8,
  parameter int NUM_DRIVES = 2
) (
  input  logic                  clk,
  input  logic                  coldRst,
  input  logic                  warmRst,
  input  bayStrobesT            strobes,
  input  logic [DATA_W-1:0]     wrData,
  input  logic [NUM_DRIVES-1:0] drivePresent,
  output logic [DATA_W-1:0]     rdData,
  output logic [NUM_DRIVES-1:0] faultLed,
  output logic [NUM_DRIVES-1:0] drivePower
);

  logic [NUM_DRIVES-1:0] faultQ;
  logic [NUM_DRIVES-1:0] powerQ;
  logic                  unusedHighData;

  assign unusedHighData = ^wrData[DATA_W-1:NUM_DRIVES];

  // One flop pair per drive bay
  for (genvar d = 0; d < NUM_DRIVES; d++) begin : g_bay
    always_ff @(posedge clk) begin
      if (strobes.clearFault)   faultQ[d] <= 1'b0;
      else if (strobes.faultWr) faultQ[d] <= wrData[d];

      if (strobes.loadPower)    powerQ[d] <= drivePresent[d];
      else if (strobes.powerWr) powerQ[d] <= wrData[d];
    end
  end

  always_comb begin
    rdData = '0;
    if (strobes.faultRd)      rdData[NUM_DRIVES-1:0] = faultQ;
    else if (strobes.powerRd) rdData[NUM_DRIVES-1:0] = powerQ;
  end

  assign faultLed   = faultQ;
  assign drivePower = powerQ;

  // R4: reserved read bits stay zero
  a_r4_reserved_zero: assert property (@(posedge clk) disable iff (coldRst)
    rdData[DATA_W-1:NUM_DRIVES] == '0);

  // R5: warm reset does not disturb drive power
  a_r5_warm_keeps_power: assert property (@(posedge clk) disable iff (coldRst)
    warmRst |=> $stable(drivePower));

  // R6: warm reset clears the indicators
  a_r6_warm_clears_fault: assert property (@(posedge clk) disable iff (coldRst)
    warmRst |=> (faultLed == '0));

  // R7: leaving cold reset, power equals the last presence value sampled
  a_r7_cold_loads_power: assert property (@(posedge clk) disable iff (warmRst)
    $fell(coldRst) |-> (drivePower == $past(drivePresent)));

  // R3: a decoded fault write lands on the next edge
  a_r3_fault_write: assert property (@(posedge clk) disable iff (coldRst || warmRst)
    strobes.faultWr |=> (faultLed == $past(wrData[NUM_DRIVES-1:0])));

endmodule

// File: rtl/drive_bay_regs.sv
module drive_bay_regs
  import drive_bay_pkg::*;
#(
  parameter int ADDR_W       = 16,
  parameter int DATA_W       = 8,
  parameter int NUM_DRIVES   = 2,
  parameter int OFFSET_W     = 8,
  parameter int REGION_W     = 3,
  parameter logic [ADDR_W-1:0] WINDOW_BASE = 16'hF800,
  parameter int FAULT_REGION = 0,
  parameter int POWER_REGION = 1
) (
  input  logic                  clk,
  input  logic                  coldRst,
  input  logic                  warmRst,
  input  logic [ADDR_W-1:0]     addr,
  input  logic                  wrEn,
  input  logic [DATA_W-1:0]     wrData,
  input  logic                  rdEn,
  output logic [DATA_W-1:0]     rdData,
  input  logic [NUM_DRIVES-1:0] drivePresent,
  output logic [NUM_DRIVES-1:0] faultLed,
  output logic [NUM_DRIVES-1:0] drivePower
);

  bayStrobesT strobes;

  drive_bay_ctrl #(
    .ADDR_W(ADDR_W), .OFFSET_W(OFFSET_W), .REGION_W(REGION_W),
    .WINDOW_BASE(WINDOW_BASE), .FAULT_REGION(FAULT_REGION),
    .POWER_REGION(POWER_REGION)
  ) uCtrl (
    .coldRst(coldRst), .warmRst(warmRst), .addr(addr),
    .wrEn(wrEn), .rdEn(rdEn), .strobes(strobes)
  );

  drive_bay_dp #(
    .DATA_W(DATA_W), .NUM_DRIVES(NUM_DRIVES)
  ) uDp (
    .clk(clk), .coldRst(coldRst), .warmRst(warmRst), .strobes(strobes),
    .wrData(wrData), .drivePresent(drivePresent), .rdData(rdData),
    .faultLed(faultLed), .drivePower(drivePower)
  );

  // R8: a read that selects no implemented register returns zero
  a_r8_miss_reads_zero: assert property (@(posedge clk) disable iff (coldRst)
    !(strobes.faultRd || strobes.powerRd) |-> (rdData == '0));

endmodule

// File: tb/drive_bay_regs_test.sv
module drive_bay_regs_test;

  logic        clk = 1'b0;
  logic        coldRst, warmRst, wrEn, rdEn;
  logic [15:0] addr;
  logic [7:0]  wrData, rdData;
  logic [1:0]  drivePresent, faultLed, drivePower;
  int          checks = 0;
  int          fails = 0;
  bit          done = 1'b0;

  always #2 clk = ~clk;

  drive_bay_regs uut (
    .clk(clk), .coldRst(coldRst), .warmRst(warmRst), .addr(addr),
    .wrEn(wrEn), .wrData(wrData), .rdEn(rdEn), .rdData(rdData),
    .drivePresent(drivePresent), .faultLed(faultLed), .drivePower(drivePower)
  );

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic busWrite(input logic [15:0] a, input logic [7:0] d);
    @(negedge clk);
    addr = a; wrData = d; wrEn = 1'b1;
    @(posedge clk); #1;
    wrEn = 1'b0;
  endtask

  task automatic busRead(input logic [15:0] a, output logic [7:0] d);
    @(negedge clk);
    addr = a; rdEn = 1'b1;
    #1 d = rdData;
    rdEn = 1'b0;
  endtask

  task automatic pulseRst(input logic cold, input logic warm);
    @(negedge clk);
    coldRst = cold; warmRst = warm;
    @(posedge clk); #1;
    coldRst = 1'b0; warmRst = 1'b0;
  endtask

  task automatic t_reset_state();
    logic [7:0] d;
    check("R7 power after cold reset", {6'b0, drivePower}, 8'h02);
    check("R6 fault after cold reset", {6'b0, faultLed}, 8'h00);
    busRead(16'hF900, d);
    check("R4 power readback", d, 8'h02);
    #1 check("R4 idle read is zero", rdData, 8'h00);
  endtask

  task automatic t_fault_write_alias();
    logic [7:0] d;
    busWrite(16'hF8FF, 8'hFD);
    check("R3 fault led outputs", {6'b0, faultLed}, 8'h01);
    busRead(16'hF800, d);
    check("R2 alias read at offset 00", d, 8'h01);
    busRead(16'hF87A, d);
    check("R4 reserved bits read zero", d, 8'h01);
    busWrite(16'hF842, 8'h02);
    check("R1 fault region decode", {6'b0, faultLed}, 8'h02);
  endtask

  task automatic t_power_write();
    logic [7:0] d;
    busWrite(16'hF9C3, 8'h03);
    check("R3 power outputs", {6'b0, drivePower}, 8'h03);
    busRead(16'hF901, d);
    check("R1 power region decode", d, 8'h03);
  endtask

  task automatic t_unused_regions();
    logic [7:0] d;
    for (int r = 2; r < 8; r++) begin
      busWrite({5'b11111, r[2:0], 8'h10}, 8'h00);
      busRead({5'b11111, r[2:0], 8'h10}, d);
      check("R8 unused region reads zero", d, 8'h00);
    end
    check("R8 fault untouched", {6'b0, faultLed}, 8'h02);
    check("R8 power untouched", {6'b0, drivePower}, 8'h03);
    busWrite(16'hE800, 8'h00);
    busWrite(16'h7900, 8'h00);
    busRead(16'hE800, d);
    check("R8 outside window reads zero", d, 8'h00);
    check("R8 outside write ignored", {faultLed, drivePower, 4'b0}, 8'hB0);
  endtask

  task automatic t_warm_reset();
    pulseRst(1'b0, 1'b1);
    check("R6 warm clears fault", {6'b0, faultLed}, 8'h00);
    check("R5 warm keeps power", {6'b0, drivePower}, 8'h03);
  endtask

  task automatic t_write_during_reset();
    @(negedge clk);
    warmRst = 1'b1; addr = 16'hF900; wrData = 8'h00; wrEn = 1'b1;
    @(posedge clk); #1;
    warmRst = 1'b0; wrEn = 1'b0;
    check("R6 write ignored in reset", {6'b0, drivePower}, 8'h03);
  endtask

  task automatic t_cold_priority();
    busWrite(16'hF800, 8'h03);
    drivePresent = 2'b01;
    pulseRst(1'b1, 1'b1);
    check("R7 cold wins over warm", {6'b0, drivePower}, 8'h01);
    check("R6 cold clears fault", {6'b0, faultLed}, 8'h00);
    drivePresent = 2'b00;
    pulseRst(1'b1, 1'b0);
    check("R7 no drives present", {6'b0, drivePower}, 8'h00);
  endtask

  initial begin
    coldRst = 1'b1; warmRst = 1'b0; wrEn = 1'b0; rdEn = 1'b0;
    addr = '0; wrData = '0; drivePresent = 2'b10;
    repeat (3) @(posedge clk);
    #1 coldRst = 1'b0;
    t_reset_state();
    t_fault_write_alias();
    t_power_write();
    t_unused_regions();
    t_warm_reset();
    t_write_during_reset();
    t_cold_priority();
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    #40000;
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

endmodule